// File: doc/BRIEF.md
# Bus Crosstalk Transition Cost Monitor

This block observes words moving over a parallel bus and, for every accepted word, measures the cost of switching from the previously accepted word. The cost has two parts. The self count is the number of wires that change level. The coupling count adds up, over every pair of neighbouring wires, how far the voltage difference across that pair moves. The weighted total is the self count plus the coupling count times a programmable coupling weight. The weight is the ratio of coupling capacitance to self capacitance, and it is usually a fraction somewhere between 2 and 10.

Words arrive on a valid/ready stream. The monitor never applies back-pressure: `in_ready` is always high, and a word is taken on every clock edge where `in_valid` is high. The results for each transfer are registered and shown for one cycle, qualified by `out_valid`. Three saturating running totals collect the self count, the coupling count and the weighted total, so a tool or a test can compare code assignments over a whole trace. A synchronous clear resets the running totals.

Top module: `xtc_cost_mon`

## Requirements
- R1: After reset, `out_valid`, the per-transfer outputs and all three running totals are zero, and the stored previous word is all zeros, so the first accepted word is compared with zero.
- R2: `out_self` equals the number of bit positions in which the accepted word differs from the previously accepted word.
- R3: `out_coup` is the sum, over each neighbouring wire pair (i, i+1), of |(new[i] - new[i+1]) - (old[i] - old[i+1])|. A pair adds 0, 1 or 2, and adds 2 when its two wires toggle in opposite directions. Going from 0000 to 0101 gives 2 self and 3 coupling, and going from 0000 to 1111 gives 4 self and 0 coupling.
- R4: `out_cost` equals `out_self` * 256 + `in_weight` * `out_coup`, kept at full precision with 8 fractional bits. `in_weight` is unsigned Q4.8, so the value 256 means 1.0.
- R5: The per-transfer outputs update on the clock edge that accepts a word, and `out_valid` is high in the cycle after that edge only. When no word is accepted, `out_valid` is low and the per-transfer outputs keep their values.
- R6: A word presented while `in_valid` is low has no effect. The stored previous word changes only when a word is accepted.
- R7: On each accepted word, every running total adds that transfer's value. The addition takes effect on the same edge as the per-transfer outputs.
- R8: A running total that would go past its all-ones maximum stays at all ones.
- R9: When `acc_clr` is high at a clock edge, all running totals become zero on that edge. This takes priority over a transfer accepted on the same edge, whose per-transfer outputs and previous-word update still happen.
- R10: `in_ready` is high in every cycle after reset.
- R11: The weight is sampled on the edge that accepts the word. A weight change while no word is accepted does not affect later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Bus word present |
| in_ready | output | 1 | Always high, no back-pressure |
| in_word | input | BUS_W | Bus word |
| in_weight | input | WT_W (12) | Coupling weight, unsigned Q4.8 |
| acc_clr | input | 1 | Synchronous clear of the running totals |
| out_valid | output | 1 | Per-transfer results valid for this cycle |
| out_self | output | SELF_W | Self transitions of the last transfer |
| out_coup | output | COUP_W | Coupling transitions of the last transfer |
| out_cost | output | COST_W | Weighted total of the last transfer, Q.8 |
| acc_self | output | CNT_ACC_W | Saturating total of self transitions |
| acc_coup | output | CNT_ACC_W | Saturating total of coupling transitions |
| acc_cost | output | COST_ACC_W | Saturating total of weighted cost |

## Verification
The hardest state to reach from the ports is saturation of the running totals, because the default totals are wide. The bench therefore narrows them through parameters and then drives a long run of alternating 0101 and 1010 words at the largest weight. Each of these transfers toggles every wire, and every pair toggles in opposite directions, so each transfer gives the largest possible count. The bench also sets up a clear on the same edge as an accepted word, and it changes the word and the weight during idle cycles to show that neither is captured.

// File: rtl/xtc_pkg.sv
package xtc_pkg;
  localparam int WT_INT_BITS  = 4;
  localparam int WT_FRAC_BITS = 8;
  localparam int WT_W         = WT_INT_BITS + WT_FRAC_BITS;

  // Contribution of one neighbouring wire pair to the coupling count
  typedef enum logic [1:0] {
    PAIR_QUIET  = 2'd0,
    PAIR_SINGLE = 2'd1,
    PAIR_OPPOSE = 2'd2
  } pair_kind_e;

  function automatic pair_kind_e classify_pair(input logic tog_lo, input logic tog_hi,
                                               input logic old_lo, input logic old_hi);
    if (tog_lo && tog_hi)
      return (old_lo != old_hi) ? PAIR_OPPOSE : PAIR_QUIET;
    else if (tog_lo || tog_hi)
      return PAIR_SINGLE;
    else
      return PAIR_QUIET;
  endfunction
endpackage

// File: rtl/xtc_pair_diff.sv
module xtc_pair_diff
  import xtc_pkg::*;
#(
  parameter int BUS_W  = 4,
  parameter int SELF_W = $clog2(BUS_W + 1),
  parameter int COUP_W = $clog2(2 * (BUS_W - 1) + 1)
) (
  input  logic [BUS_W-1:0]  prev_word,
  input  logic [BUS_W-1:0]  cur_word,
  output logic [SELF_W-1:0] self_cnt,
  output logic [COUP_W-1:0] coup_cnt
);
  localparam int PAIRS = BUS_W - 1;

  logic [BUS_W-1:0]   tog;
  logic [2*PAIRS-1:0] pair_w;

  assign tog = prev_word ^ cur_word;

  generate
    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
      assign pair_w[2*i +: 2] = classify_pair(tog[i], tog[i+1], prev_word[i], prev_word[i+1]);
    end
  endgenerate

  always_comb begin
    self_cnt = '0;
    for (int i = 0; i < BUS_W; i++) self_cnt = self_cnt + SELF_W'(tog[i]);
  end

  always_comb begin
    coup_cnt = '0;
    for (int i = 0; i < PAIRS; i++) coup_cnt = coup_cnt + COUP_W'(pair_w[2*i +: 2]);
  end
endmodule

// File: rtl/xtc_weight.sv
module xtc_weight
  import xtc_pkg::*;
#(
  parameter int SELF_W = 3,
  parameter int COUP_W = 3,
  parameter int COST_W = WT_W + COUP_W + 1
) (
  input  logic [SELF_W-1:0] self_cnt,
  input  logic [COUP_W-1:0] coup_cnt,
  input  logic [WT_W-1:0]   weight,
  output logic [COST_W-1:0] cost
);
  logic [COST_W-1:0] self_q;
  logic [COST_W-1:0] coup_q;

  assign self_q = COST_W'(self_cnt) << WT_FRAC_BITS;
  assign coup_q = COST_W'(weight) * COST_W'(coup_cnt);
  assign cost   = self_q + coup_q;
endmodule

// File: rtl/xtc_sat_acc.sv
module xtc_sat_acc #(
  parameter int IN_W  = 3,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [IN_W-1:0]  inc,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W:0] sum;

  assign sum = {1'b0, acc} + (ACC_W + 1)'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (clr)    acc <= '0;
    else if (add_en) acc <= sum[ACC_W] ? '1 : sum[ACC_W-1:0];
  end
endmodule

// File: rtl/xtc_cost_mon.sv
module xtc_cost_mon
  import xtc_pkg::*;
#(
  parameter int BUS_W      = 4,
  parameter int CNT_ACC_W  = 32,
  parameter int COST_ACC_W = 32,
  localparam int SELF_W    = $clog2(BUS_W + 1),
  localparam int COUP_W    = $clog2(2 * (BUS_W - 1) + 1),
  localparam int COST_W    = WT_W + COUP_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [BUS_W-1:0]      in_word,
  input  logic [WT_W-1:0]       in_weight,
  input  logic                  acc_clr,
  output logic                  out_valid,
  output logic [SELF_W-1:0]     out_self,
  output logic [COUP_W-1:0]     out_coup,
  output logic [COST_W-1:0]     out_cost,
  output logic [CNT_ACC_W-1:0]  acc_self,
  output logic [CNT_ACC_W-1:0]  acc_coup,
  output logic [COST_ACC_W-1:0] acc_cost
);
  logic [BUS_W-1:0]  prev_word;
  logic [SELF_W-1:0] self_nx;
  logic [COUP_W-1:0] coup_nx;
  logic [COST_W-1:0] cost_nx;
  logic              take;

  assign in_ready = 1'b1;
  assign take     = in_valid;

  xtc_pair_diff #(.BUS_W(BUS_W), .SELF_W(SELF_W), .COUP_W(COUP_W)) i_diff (
    .prev_word (prev_word),
    .cur_word  (in_word),
    .self_cnt  (self_nx),
    .coup_cnt  (coup_nx)
  );

  xtc_weight #(.SELF_W(SELF_W), .COUP_W(COUP_W), .COST_W(COST_W)) i_weight (
    .self_cnt (self_nx),
    .coup_cnt (coup_nx),
    .weight   (in_weight),
    .cost     (cost_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_word <= '0;
      out_valid <= 1'b0;
      out_self  <= '0;
      out_coup  <= '0;
      out_cost  <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        prev_word <= in_word;
        out_self  <= self_nx;
        out_coup  <= coup_nx;
        out_cost  <= cost_nx;
      end
    end
  end

  xtc_sat_acc #(.IN_W(SELF_W), .ACC_W(CNT_ACC_W)) i_acc_self (
    .clk (clk), .rst_n (rst_n), .clr (acc_clr), .add_en (take), .inc (self_nx), .acc (acc_self)
  );

  xtc_sat_acc #(.IN_W(COUP_W), .ACC_W(CNT_ACC_W)) i_acc_coup (
    .clk (clk), .rst_n (rst_n), .clr (acc_clr), .add_en (take), .inc (coup_nx), .acc (acc_coup)
  );

  xtc_sat_acc #(.IN_W(COST_W), .ACC_W(COST_ACC_W)) i_acc_cost (
    .clk (clk), .rst_n (rst_n), .clr (acc_clr), .add_en (take), .inc (cost_nx), .acc (acc_cost)
  );
endmodule

// File: rtl/xtc_cost_chk.sv
module xtc_cost_chk #(
  parameter int BUS_W      = 4,
  parameter int SELF_W     = 3,
  parameter int COUP_W     = 3,
  parameter int COST_W     = 16,
  parameter int CNT_ACC_W  = 32,
  parameter int COST_ACC_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  acc_clr,
  input logic                  out_valid,
  input logic [SELF_W-1:0]     out_self,
  input logic [COUP_W-1:0]     out_coup,
  input logic [COST_W-1:0]     out_cost,
  input logic [CNT_ACC_W-1:0]  acc_self,
  input logic [CNT_ACC_W-1:0]  acc_coup,
  input logic [COST_ACC_W-1:0] acc_cost
);
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  p_valid_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_self) && $stable(out_coup) && $stable(out_cost)));

  p_self_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_self <= SELF_W'(BUS_W));

  p_coup_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_coup <= COUP_W'(2 * (BUS_W - 1)));

  p_cost_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_cost >= (COST_W'(out_self) << 8));

  p_monotone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_clr) |-> (acc_self >= $past(acc_self) && acc_coup >= $past(acc_coup)
                         && acc_cost >= $past(acc_cost)));

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cost == '1 && !acc_clr) |=> acc_cost == '1);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_clr) |-> (acc_self == '0 && acc_coup == '0 && acc_cost == '0));
endmodule

bind xtc_cost_mon xtc_cost_chk #(
  .BUS_W(BUS_W), .SELF_W(SELF_W), .COUP_W(COUP_W), .COST_W(COST_W),
  .CNT_ACC_W(CNT_ACC_W), .COST_ACC_W(COST_ACC_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .acc_clr(acc_clr),
  .out_valid(out_valid), .out_self(out_self), .out_coup(out_coup), .out_cost(out_cost),
  .acc_self(acc_self), .acc_coup(acc_coup), .acc_cost(acc_cost)
);

// File: tb/test_xtc_cost_mon.sv
module test_xtc_cost_mon;
  localparam int CLK_P      = 10;
  localparam int BUS_W      = 4;
  localparam int CNT_ACC_W  = 8;
  localparam int COST_ACC_W = 16;
  localparam longint CNT_MAX  = (64'd1 << CNT_ACC_W) - 1;
  localparam longint COST_MAX = (64'd1 << COST_ACC_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [BUS_W-1:0] in_word = '0;
  logic [11:0] in_weight = '0;
  logic acc_clr = 1'b0;
  logic out_valid;
  logic [2:0] out_self;
  logic [2:0] out_coup;
  logic [15:0] out_cost;
  logic [CNT_ACC_W-1:0] acc_self;
  logic [CNT_ACC_W-1:0] acc_coup;
  logic [COST_ACC_W-1:0] acc_cost;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  // reference state
  int m_prev[BUS_W];
  bit m_valid;
  longint m_self, m_coup, m_cost, m_as, m_ac, m_acost;

  always #(CLK_P/2) clk = ~clk;

  xtc_cost_mon #(.BUS_W(BUS_W), .CNT_ACC_W(CNT_ACC_W), .COST_ACC_W(COST_ACC_W)) i_xtc_cost_mon (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .in_weight(in_weight), .acc_clr(acc_clr), .out_valid(out_valid), .out_self(out_self),
    .out_coup(out_coup), .out_cost(out_cost), .acc_self(acc_self), .acc_coup(acc_coup),
    .acc_cost(acc_cost)
  );

  task automatic chk(string req, string what, longint got, longint exp);
    if (got != exp) begin
      misses++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    vectors++;
    chk("R10", "in_ready", longint'(in_ready), 1);
    chk("R5", "out_valid", longint'(out_valid), longint'(m_valid));
    chk("R2", "out_self", longint'(out_self), m_self);
    chk("R3", "out_coup", longint'(out_coup), m_coup);
    chk("R4", "out_cost", longint'(out_cost), m_cost);
    chk("R7", "acc_self", longint'(acc_self), m_as);
    chk("R7", "acc_coup", longint'(acc_coup), m_ac);
    chk("R7", "acc_cost", longint'(acc_cost), m_acost);
  endtask

  function automatic longint sat(longint a, longint mx);
    return (a > mx) ? mx : a;
  endfunction

  // One cycle: check what the last edge produced, then present the next inputs
  task automatic drive(bit v, logic [BUS_W-1:0] w, int lam, bit clr);
    longint s, c, d_old, d_new, dd;
    @(negedge clk);
    compare();
    in_valid = v; in_word = w; in_weight = 12'(lam); acc_clr = clr;
    s = 0; c = 0;
    if (v) begin
      for (int i = 0; i < BUS_W; i++) if (m_prev[i] != int'(w[i])) s++;
      for (int i = 0; i < BUS_W - 1; i++) begin
        d_old = m_prev[i] - m_prev[i+1];
        d_new = int'(w[i]) - int'(w[i+1]);
        dd = d_new - d_old;
        c += (dd < 0) ? -dd : dd;
      end
      m_self = s; m_coup = c; m_cost = s * 256 + longint'(lam) * c;
      for (int i = 0; i < BUS_W; i++) m_prev[i] = int'(w[i]);
    end
    m_valid = v;
    if (clr) begin
      m_as = 0; m_ac = 0; m_acost = 0;
    end else if (v) begin
      m_as = sat(m_as + s, CNT_MAX);
      m_ac = sat(m_ac + c, CNT_MAX);
      m_acost = sat(m_acost + m_cost, COST_MAX);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < BUS_W; i++) m_prev[i] = 0;
    m_valid = 0; m_self = 0; m_coup = 0; m_cost = 0; m_as = 0; m_ac = 0; m_acost = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "out_valid", longint'(out_valid), 0);
    chk("R1", "out_cost", longint'(out_cost), 0);
    chk("R1", "acc_cost", longint'(acc_cost), 0);
    chk("R1", "acc_self", longint'(acc_self), 0);

    // R3: from zero to 0101 costs 2 self and 3 coupling at weight 1.0
    drive(1, 4'b0101, 256, 0);
    drive(0, 4'b1111, 4095, 0);
    chk("R2", "self 0000->0101", longint'(out_self), 2);
    chk("R3", "coup 0000->0101", longint'(out_coup), 3);
    chk("R4", "cost 0000->0101", longint'(out_cost), 1280);

    // R6: the idle 1111 was not captured, so 0101 again costs nothing
    drive(1, 4'b0101, 100, 0);
    drive(0, 4'b1010, 4095, 0);
    chk("R6", "self after idle word", longint'(out_self), 0);

    // R11: weight changed while idle; 0101->0000 at weight 446 (about 1.742)
    drive(1, 4'b0000, 446, 0);
    drive(0, 4'b0000, 0, 0);
    chk("R11", "cost with sampled weight", longint'(out_cost), 512 + 3 * 446);

    // R4: 0000->1111 costs 4 self and no coupling at weight 2514 (about 9.82)
    drive(1, 4'b1111, 2514, 0);
    drive(0, 4'b0000, 0, 0);
    chk("R4", "cost 0000->1111", longint'(out_cost), 1024);
    chk("R3", "coup 0000->1111", longint'(out_coup), 0);

    // mixed traffic, compared against the reference every cycle
    for (int k = 0; k < 400; k++)
      drive(1'($urandom_range(0, 2) != 0), 4'($urandom), int'($urandom_range(0, 4095)),
            $urandom_range(0, 19) == 0);

    // R9: a clear on the same edge as a transfer wins for the totals
    drive(1, 4'b0110, 777, 0);
    drive(1, 4'b1001, 777, 1);
    drive(0, 4'b0000, 0, 0);
    chk("R9", "acc_self after clear", longint'(acc_self), 0);
    chk("R9", "acc_cost after clear", longint'(acc_cost), 0);
    chk("R9", "self of cleared transfer", longint'(out_self), 4);

    // R8: push the totals to saturation with the costliest transfers
    for (int k = 0; k < 150; k++)
      drive(1, (k % 2 == 0) ? 4'b0101 : 4'b1010, 4095, 0);
    drive(0, 4'b0000, 0, 0);
    chk("R8", "acc_self saturated", longint'(acc_self), CNT_MAX);
    chk("R8", "acc_coup saturated", longint'(acc_coup), CNT_MAX);
    chk("R8", "acc_cost saturated", longint'(acc_cost), COST_MAX);
    chk("R3", "coup opposite toggles", longint'(out_coup), 6);

    drive(0, 4'b0000, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule